// File: doc/BRIEF.md
# Two-Stage Clock Divider with Source Selector

This block derives a slower clock from one of four candidate sources. Each source is modelled as a one-cycle tick in a single reference clock domain: a tick marks one active edge of that source. The ticks of the chosen source first pass through a power-of-two prescaler and then through an integer divider. The total ratio is therefore (integer field + 1) shifted left by the prescaler exponent, which gives 1 to 256 source ticks per output period.

Software programs one 32-bit control word through a plain synchronous write port with byte strobes, and it can read the word back at any time. The block drives a divided clock level and a one-cycle strobe at the output rate. A new setting, including a new source choice, is held pending and only takes over when the current output period ends. Because of this, a reprogramming never cuts a period short.

Top module: `twostage_clkgen`

## Requirements
- R1: While reset is held and in the first cycle after it, the control word reads 0x00000000, `div_clk` is low and `div_stb` is low. That state means source 0, exponent 0 and integer field 0.
- R2: The source select sits in control bits 17:16, the prescaler exponent in bits 5:4 and the integer field in bits 12:8. Every other bit reads zero and ignores writes.
- R3: A write changes only the bytes whose `reg_be` bit is set. Byte 0 carries the exponent, byte 1 the integer field and byte 2 the select. Byte 3 holds no field, so a write to it alone leaves the word unchanged.
- R4: Only ticks of the active source move the period position. Ticks on the other inputs have no effect on either output.
- R5: With ratio N = (integer field + 1) << exponent, `div_stb` pulses once for every N ticks of the active source. The pulse comes in the cycle after the edge that samples the N-th tick.
- R6: Within a period, `div_clk` is high while the number of ticks counted so far is below floor(N/2), and low otherwise. Even N gives a 50% duty cycle. Odd N is high for floor(N/2) ticks. For N = 1 the output stays low.
- R7: Written values of all three fields are copied into the active setting only at the edge that completes a period. Until then the old ratio and source stay in force.
- R8: With N = 1 and the active source ticking every reference cycle, `div_stb` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | One tick per active edge of each candidate source |
| reg_we | input | 1 | Write strobe for the control word |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word (pending setting) |
| div_clk | output | 1 | Divided clock level |
| div_stb | output | 1 | One-cycle pulse per output period |

## Verification
A wrong prescaler or divider count shows up in `div_clk` on the next tick of the active source. It shows up in `div_stb` by the end of the period at the latest. A setting that is adopted too early, or a source that is switched too early, moves the next strobe. The cycle-exact model sees that at the first strobe after the write. A field-packing or byte-strobe fault appears on `reg_rdata` in the cycle right after the write.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int NUM_SRC = 4;
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int EXP_W   = 2;
  localparam int DIV_W   = 5;
  localparam int REG_W   = 32;
  localparam int BE_W    = REG_W / 8;
  localparam int SEL_LSB = 16;
  localparam int EXP_LSB = 4;
  localparam int DIV_LSB = 8;
  localparam int PRE_CW  = (1 << EXP_W) - 1;
  localparam int POS_W   = DIV_W + PRE_CW;
  localparam int RAT_W   = POS_W + 1;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [EXP_W-1:0] expo;
    logic [DIV_W-1:0] dv;
  } cfg_t;

  function automatic logic [REG_W-1:0] field_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[SEL_LSB +: SEL_W] = '1;
    m[EXP_LSB +: EXP_W] = '1;
    m[DIV_LSB +: DIV_W] = '1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] pack_cfg(cfg_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[SEL_LSB +: SEL_W] = c.sel;
    r[EXP_LSB +: EXP_W] = c.expo;
    r[DIV_LSB +: DIV_W] = c.dv;
    return r;
  endfunction

  function automatic cfg_t unpack_cfg(logic [REG_W-1:0] r);
    cfg_t c;
    c.sel  = r[SEL_LSB +: SEL_W];
    c.expo = r[EXP_LSB +: EXP_W];
    c.dv   = r[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [PRE_CW-1:0] pre_limit(logic [EXP_W-1:0] e);
    return PRE_CW'((32'd1 << e) - 32'd1);
  endfunction

  function automatic logic [RAT_W-1:0] ratio(cfg_t c);
    return RAT_W'((32'(c.dv) + 32'd1) << c.expo);
  endfunction

  function automatic logic [POS_W-1:0] position(logic [PRE_CW-1:0] p,
                                                logic [DIV_W-1:0] d,
                                                logic [EXP_W-1:0] e);
    return POS_W'((32'(d) << e) | 32'(p));
  endfunction

  function automatic logic high_phase(logic [POS_W-1:0] pos, cfg_t c);
    return {1'b0, pos} < (ratio(c) >> 1);
  endfunction
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [BE_W-1:0]  be,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output cfg_t             cfg
);
  localparam logic [REG_W-1:0] MASK = field_mask();

  logic [REG_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (we) begin
      for (int b = 0; b < BE_W; b++) begin
        if (be[b]) word_q[b*8 +: 8] <= wdata[b*8 +: 8] & MASK[b*8 +: 8];
      end
    end
  end

  assign rdata = pack_cfg(unpack_cfg(word_q));
  assign cfg   = unpack_cfg(word_q);
endmodule

// File: rtl/tsc_srcsel.sv
module tsc_srcsel
  import tsc_pkg::*;
(
  input  logic [NUM_SRC-1:0] ticks,
  input  logic [SEL_W-1:0]   sel,
  output logic               sel_tick
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit[i] = ticks[i] & (sel == SEL_W'(i));
  end

  assign sel_tick = |hit;
endmodule

// File: rtl/tsc_prescale.sv
module tsc_prescale
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [EXP_W-1:0]  expo,
  output logic [PRE_CW-1:0] pre_q,
  output logic [PRE_CW-1:0] pre_nxt,
  output logic              pre_wrap
);
  always_comb begin
    pre_wrap = tick && (pre_q == pre_limit(expo));
    if (!tick)        pre_nxt = pre_q;
    else if (pre_wrap) pre_nxt = '0;
    else              pre_nxt = pre_q + PRE_CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_nxt;
  end
endmodule

// File: rtl/tsc_intdiv.sv
module tsc_intdiv
  import tsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [DIV_W-1:0] dv,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] div_nxt,
  output logic             period_end
);
  always_comb begin
    period_end = step && (div_q == dv);
    if (!step)           div_nxt = div_q;
    else if (period_end) div_nxt = '0;
    else                 div_nxt = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_nxt;
  end
endmodule

// File: rtl/twostage_clkgen.sv
module twostage_clkgen
  import tsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               reg_we,
  input  logic [BE_W-1:0]    reg_be,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               div_clk,
  output logic               div_stb
);
  cfg_t              cfg;
  cfg_t              act_q;
  cfg_t              act_nxt;
  logic              sel_tick;
  logic              pre_wrap;
  logic              boundary;
  logic [PRE_CW-1:0] pre_q, pre_nxt;
  logic [DIV_W-1:0]  div_q, div_nxt;
  logic              clk_nxt;

  tsc_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .be(reg_be), .wdata(reg_wdata),
    .rdata(reg_rdata), .cfg(cfg)
  );

  tsc_srcsel u_sel (
    .ticks(src_tick), .sel(act_q.sel), .sel_tick(sel_tick)
  );

  tsc_prescale u_pre (
    .clk(clk), .rst(rst), .tick(sel_tick), .expo(act_q.expo),
    .pre_q(pre_q), .pre_nxt(pre_nxt), .pre_wrap(pre_wrap)
  );

  tsc_intdiv u_div (
    .clk(clk), .rst(rst), .step(pre_wrap), .dv(act_q.dv),
    .div_q(div_q), .div_nxt(div_nxt), .period_end(boundary)
  );

  always_comb begin
    act_nxt = boundary ? cfg : act_q;
    clk_nxt = high_phase(position(pre_nxt, div_nxt, act_nxt.expo), act_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= '0;
      div_clk <= 1'b0;
      div_stb <= 1'b0;
    end else begin
      act_q   <= act_nxt;
      div_clk <= clk_nxt;
      div_stb <= boundary;
    end
  end
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk
  import tsc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sel_tick,
  input logic              boundary,
  input cfg_t              act_q,
  input logic [PRE_CW-1:0] pre_q,
  input logic [DIV_W-1:0]  div_q,
  input logic              reg_we,
  input logic [BE_W-1:0]   reg_be,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              div_clk,
  input logic              div_stb
);
  localparam logic [REG_W-1:0] MASK = field_mask();

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && !div_stb && !div_clk));

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~MASK) == '0);

  assert_no_field_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!reg_we || reg_be[BE_W-2:0] == '0) |=> $stable(reg_rdata));

  assert_idle_source_R4: assert property (@(posedge clk) disable iff (rst)
    !sel_tick |=> ($stable(pre_q) && $stable(div_q)));

  assert_stb_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
    div_stb |-> $past(sel_tick));

  assert_unit_ratio_low_R6: assert property (@(posedge clk) disable iff (rst)
    (act_q.expo == '0 && act_q.dv == '0) |-> !div_clk);

  assert_hold_setting_R7: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(act_q));

  assert_unit_ratio_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (act_q.expo == '0 && act_q.dv == '0 && sel_tick) |=> div_stb);
endmodule

bind twostage_clkgen tsc_chk u_chk (
  .clk(clk), .rst(rst), .sel_tick(sel_tick), .boundary(boundary),
  .act_q(act_q), .pre_q(pre_q), .div_q(div_q), .reg_we(reg_we),
  .reg_be(reg_be), .reg_rdata(reg_rdata), .div_clk(div_clk),
  .div_stb(div_stb)
);

// File: tb/tb_twostage_clkgen.sv
`timescale 1ns/1ps
module tb_twostage_clkgen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  src_tick = 4'h0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_be = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        div_clk, div_stb;

  always #2.5 clk = ~clk;

  twostage_clkgen dut (
    .clk(clk), .rst(rst), .src_tick(src_tick), .reg_we(reg_we),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .div_clk(div_clk), .div_stb(div_stb)
  );

  int total = 0;
  int bad = 0;
  bit chk_on = 0;
  string req = "R1";
  bit tick_rand = 0;
  logic [3:0] tick_mask = 4'hF;

  int m_sel = 0, m_exp = 0, m_div = 0;
  int a_sel = 0, a_exp = 0, a_div = 0;
  int m_cnt = 0;
  bit e_stb = 0, e_clk = 0;

  function automatic int word_exp();
    return (m_sel << 16) | (m_div << 8) | (m_exp << 4);
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: one position counter over the whole ratio
  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_exp = 0; m_div = 0;
      a_sel = 0; a_exp = 0; a_div = 0;
      m_cnt = 0; e_stb = 0; e_clk = 0;
    end else begin
      int n;
      n = (a_div + 1) << a_exp;
      e_stb = 0;
      if (src_tick[a_sel]) begin
        if (m_cnt == n - 1) begin
          m_cnt = 0; e_stb = 1;
          a_sel = m_sel; a_exp = m_exp; a_div = m_div;
        end else begin
          m_cnt++;
        end
      end
      if (reg_we) begin
        if (reg_be[0]) m_exp = (reg_wdata >> 4) & 3;
        if (reg_be[1]) m_div = (reg_wdata >> 8) & 31;
        if (reg_be[2]) m_sel = (reg_wdata >> 16) & 3;
      end
      n = (a_div + 1) << a_exp;
      e_clk = (m_cnt < n / 2);
    end
  end

  always @(negedge clk) begin
    src_tick <= (tick_rand ? 4'($urandom) : 4'hF) & tick_mask;
    if (chk_on) begin
      check("R2", reg_rdata, word_exp());
      check(req, div_stb, e_stb);
      check("R6", div_clk, e_clk);
    end
  end

  task automatic wr(logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_be = 4'h0;
  endtask

  task automatic run(int cycles, output int pulses);
    pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (div_stb) pulses++;
    end
  endtask

  function automatic logic [31:0] cfgw(int sel, int ex, int dv);
    return (32'(sel) << 16) | (32'(dv) << 8) | (32'(ex) << 4);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    check("R1", reg_rdata, 0);
    check("R1", div_clk, 0);
    check("R1", div_stb, 0);
    rst = 1'b0;
    chk_on = 1;

    req = "R8";
    run(4, p);
    run(8, p);
    check("R8", p, 8);

    req = "R3";
    wr(4'b0010, 32'hFFFF_FFFF);
    check("R3", reg_rdata, 32'h0000_1F00);
    wr(4'b1000, 32'hFFFF_FFFF);
    check("R3", reg_rdata, 32'h0000_1F00);
    wr(4'b0100, 32'h0002_0000);
    check("R3", reg_rdata, 32'h0002_1F00);

    req = "R2";
    wr(4'b1111, 32'hFFFF_FFFF);
    check("R2", reg_rdata, 32'h0003_1F30);

    req = "R5";
    wr(4'b1111, cfgw(0, 1, 2));
    run(300, p);
    run(60, p);
    check("R5", p, 10);

    req = "R7";
    run(3, p);
    wr(4'b1111, cfgw(1, 0, 6));
    run(120, p);

    req = "R5";
    tick_rand = 1;
    wr(4'b1111, cfgw(3, 3, 4));
    run(500, p);

    req = "R4";
    wr(4'b1111, cfgw(3, 0, 1));
    run(200, p);
    tick_mask = 4'b0111;
    run(100, p);
    check("R4", p, 0);
    tick_mask = 4'hF;
    tick_rand = 0;

    req = "R6";
    wr(4'b1111, cfgw(2, 0, 4));
    run(80, p);
    wr(4'b1111, cfgw(1, 3, 31));
    run(300, p);
    run(512, p);
    check("R5", p, 2);

    req = "R8";
    wr(4'b1111, cfgw(0, 0, 0));
    run(300, p);
    run(10, p);
    check("R8", p, 10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule